// File: doc/BRIEF.md
# Load/Store Queue Allocator

This block keeps the allocation bookkeeping for the memory side of an out-of-order core. It has two circular queues, one for loads and one for stores. Each queue has a head pointer, a tail pointer and an occupancy counter. Each queue is built with one physical slot more than its usable depth, and that spare slot is what tells a full queue from an empty one. The store queue also has a writeback pointer. It marks how far stores have drained to memory, and it lies between the head and the tail.

Dispatch presents at most one memory instruction per cycle, marked as load or store. On acceptance, the block returns the slot given in the target queue. It also returns the tail of the other queue at that moment, which later stages use for age ordering. Retirement pops entries from the heads. A synchronous flush, used for pipeline handover, returns every pointer and counter to zero. Dispatch reads the free-entry output to decide how many instructions it may send.

Top module: `lsq_alloc`

## Requirements
- R1: Reset, and a cycle with `flush_i` high, clear both heads, both tails, the store writeback pointer and both occupancy counts. A dispatch in a flush cycle is not accepted.
- R2: Each queue accepts up to its usable depth (LQ_DEPTH or SQ_DEPTH) of entries. Its full output is high exactly when tail+1, modulo depth+1, equals head, which is when its count equals the depth.
- R3: A dispatch to a full queue raises `alloc_err_o` in that cycle, keeps `alloc_ok_o` low, and leaves that queue's tail and count unchanged.
- R4: An accepted load reports its slot as the current load tail. It reports the current store tail with `alloc_peer_vld_o` high, or `alloc_peer_vld_o` low when the store count is zero.
- R5: An accepted store reports its slot as the current store tail and reports the current load tail with `alloc_peer_vld_o` high.
- R6: Tails, heads and the writeback pointer step by one and wrap from index depth back to 0.
- R7: `free_o` equals min(LQ_DEPTH − load count, SQ_DEPTH − store count).
- R8: A load commit while the load queue is empty is ignored. The head and count do not change.
- R9: An accepted insert and a valid commit on the same queue in one cycle move both pointers and leave the count unchanged.
- R10: `sq_wb_i` advances the writeback pointer only while it differs from the store tail. A store commit is applied only while the store head differs from the writeback pointer, so only written-back stores retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous clear of all queue state |
| disp_valid_i | input | 1 | Dispatch request |
| disp_store_i | input | 1 | 1 = store, 0 = load |
| lq_commit_i | input | 1 | Retire the oldest load |
| sq_wb_i | input | 1 | Mark the next store as written back |
| sq_commit_i | input | 1 | Retire the oldest store |
| alloc_ok_o | output | 1 | Dispatch accepted this cycle |
| alloc_err_o | output | 1 | Dispatch dropped because the target queue is full |
| alloc_idx_o | output | IDX_W | Slot given in the target queue |
| alloc_peer_idx_o | output | IDX_W | Tail of the other queue |
| alloc_peer_vld_o | output | 1 | Peer index is meaningful (0 = none) |
| free_o | output | IDX_W | Entries dispatch may still send |
| lq_full_o | output | 1 | Load queue full |
| sq_full_o | output | 1 | Store queue full |
| lq_head_o | output | LQ_W | Load head |
| lq_tail_o | output | LQ_W | Load tail |
| lq_count_o | output | LQ_W | Load occupancy |
| sq_head_o | output | SQ_W | Store head |
| sq_tail_o | output | SQ_W | Store tail |
| sq_wb_o | output | SQ_W | Store writeback pointer |
| sq_count_o | output | SQ_W | Store occupancy |

## Verification
The assertions assume that no input is X outside reset and that the retire and writeback requests may arrive in any cycle, including on empty queues. The properties must therefore hold without any help from upstream gating. The stimulus follows that assumption. It drives every combination of the five control bits from a pseudo-random sequence, so it regularly dispatches into full queues, commits on empty ones and writes back with no stores pending. Flushes are spread through the run at fixed intervals.

// File: rtl/lsq_alloc_pkg.sv
package lsq_alloc_pkg;
  typedef enum logic {MEM_LOAD = 1'b0, MEM_STORE = 1'b1} mem_kind_e;

  function automatic int unsigned ring_next(int unsigned idx, int unsigned slots);
    return (idx + 1 >= slots) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/lsq_ring.sv
module lsq_ring #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [IDX_W-1:0] count_o,
  output logic             full_o,
  output logic             push_ok_o,
  output logic             pop_ok_o
);
  localparam int unsigned SLOTS = DEPTH + 1;

  logic [IDX_W-1:0] head_q, tail_q, cnt_q;
  logic [IDX_W-1:0] head_nx, tail_nx;
  logic             empty;

  assign tail_nx = IDX_W'(lsq_alloc_pkg::ring_next(32'(tail_q), SLOTS));
  assign head_nx = IDX_W'(lsq_alloc_pkg::ring_next(32'(head_q), SLOTS));
  // spare slot: full when the next tail would land on the head
  assign full_o    = (tail_nx == head_q);
  assign empty     = (tail_q == head_q);
  assign push_ok_o = push_i & ~full_o;
  assign pop_ok_o  = pop_i & ~empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok_o) tail_q <= tail_nx;
      if (pop_ok_o)  head_q <= head_nx;
      case ({push_ok_o, pop_ok_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = cnt_q;
endmodule

// File: rtl/lsq_wb_ptr.sv
module lsq_wb_ptr #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [IDX_W-1:0] tail_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             adv_ok_o
);
  localparam int unsigned SLOTS = DEPTH + 1;

  logic [IDX_W-1:0] ptr_q;

  assign adv_ok_o = adv_i & (ptr_q != tail_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (clr_i)    ptr_q <= '0;
    else if (adv_ok_o) ptr_q <= IDX_W'(lsq_alloc_pkg::ring_next(32'(ptr_q), SLOTS));
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/lsq_free_calc.sv
module lsq_free_calc #(
  parameter int unsigned LQ_DEPTH = 16,
  parameter int unsigned SQ_DEPTH = 16,
  parameter int unsigned LQ_W     = $clog2(LQ_DEPTH + 1),
  parameter int unsigned SQ_W     = $clog2(SQ_DEPTH + 1),
  parameter int unsigned FREE_W   = (LQ_W > SQ_W) ? LQ_W : SQ_W
) (
  input  logic [LQ_W-1:0]   lq_cnt_i,
  input  logic [SQ_W-1:0]   sq_cnt_i,
  output logic [FREE_W-1:0] free_o
);
  logic [31:0] lq_free, sq_free;

  // (slots - count) - 1 on both sides, the smaller one wins
  always_comb begin
    lq_free = LQ_DEPTH - 32'(lq_cnt_i);
    sq_free = SQ_DEPTH - 32'(sq_cnt_i);
    free_o  = (lq_free < sq_free) ? FREE_W'(lq_free) : FREE_W'(sq_free);
  end
endmodule

// File: rtl/lsq_alloc.sv
module lsq_alloc #(
  parameter int unsigned LQ_DEPTH = 16,
  parameter int unsigned SQ_DEPTH = 16,
  localparam int unsigned LQ_W  = $clog2(LQ_DEPTH + 1),
  localparam int unsigned SQ_W  = $clog2(SQ_DEPTH + 1),
  localparam int unsigned IDX_W = (LQ_W > SQ_W) ? LQ_W : SQ_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             disp_valid_i,
  input  logic             disp_store_i,
  input  logic             lq_commit_i,
  input  logic             sq_wb_i,
  input  logic             sq_commit_i,
  output logic             alloc_ok_o,
  output logic             alloc_err_o,
  output logic [IDX_W-1:0] alloc_idx_o,
  output logic [IDX_W-1:0] alloc_peer_idx_o,
  output logic             alloc_peer_vld_o,
  output logic [IDX_W-1:0] free_o,
  output logic             lq_full_o,
  output logic             sq_full_o,
  output logic [LQ_W-1:0]  lq_head_o,
  output logic [LQ_W-1:0]  lq_tail_o,
  output logic [LQ_W-1:0]  lq_count_o,
  output logic [SQ_W-1:0]  sq_head_o,
  output logic [SQ_W-1:0]  sq_tail_o,
  output logic [SQ_W-1:0]  sq_wb_o,
  output logic [SQ_W-1:0]  sq_count_o
);
  import lsq_alloc_pkg::*;

  mem_kind_e kind;
  logic      disp_live, tgt_full;
  logic      lq_push, sq_push, sq_pop;
  logic      lq_push_ok, lq_pop_ok, sq_push_ok, sq_pop_ok, wb_ok;

  assign kind      = mem_kind_e'(disp_store_i);
  assign disp_live = disp_valid_i & ~flush_i;
  assign tgt_full  = (kind == MEM_STORE) ? sq_full_o : lq_full_o;
  assign lq_push   = disp_live & (kind == MEM_LOAD);
  assign sq_push   = disp_live & (kind == MEM_STORE);
  // only stores already written back may retire
  assign sq_pop    = sq_commit_i & (sq_head_o != sq_wb_o);

  lsq_ring #(.DEPTH(LQ_DEPTH), .IDX_W(LQ_W)) u_lq (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .push_i(lq_push), .pop_i(lq_commit_i),
    .head_o(lq_head_o), .tail_o(lq_tail_o), .count_o(lq_count_o),
    .full_o(lq_full_o), .push_ok_o(lq_push_ok), .pop_ok_o(lq_pop_ok)
  );

  lsq_ring #(.DEPTH(SQ_DEPTH), .IDX_W(SQ_W)) u_sq (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .push_i(sq_push), .pop_i(sq_pop),
    .head_o(sq_head_o), .tail_o(sq_tail_o), .count_o(sq_count_o),
    .full_o(sq_full_o), .push_ok_o(sq_push_ok), .pop_ok_o(sq_pop_ok)
  );

  lsq_wb_ptr #(.DEPTH(SQ_DEPTH), .IDX_W(SQ_W)) u_wb (
    .clk_i, .rst_ni, .clr_i(flush_i),
    .adv_i(sq_wb_i), .tail_i(sq_tail_o),
    .ptr_o(sq_wb_o), .adv_ok_o(wb_ok)
  );

  lsq_free_calc #(
    .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH),
    .LQ_W(LQ_W), .SQ_W(SQ_W), .FREE_W(IDX_W)
  ) u_free (
    .lq_cnt_i(lq_count_o), .sq_cnt_i(sq_count_o), .free_o(free_o)
  );

  assign alloc_ok_o  = lq_push_ok | sq_push_ok;
  assign alloc_err_o = disp_live & tgt_full;

  always_comb begin
    if (kind == MEM_STORE) begin
      alloc_idx_o      = IDX_W'(sq_tail_o);
      alloc_peer_idx_o = IDX_W'(lq_tail_o);
      alloc_peer_vld_o = 1'b1;
    end else begin
      alloc_idx_o      = IDX_W'(lq_tail_o);
      alloc_peer_idx_o = IDX_W'(sq_tail_o);
      alloc_peer_vld_o = (sq_count_o != '0);
    end
  end

  logic unused_ok;
  assign unused_ok = lq_pop_ok ^ sq_pop_ok ^ wb_ok;
endmodule

// File: rtl/lsq_alloc_chk.sv
module lsq_alloc_chk #(
  parameter int unsigned LQ_DEPTH = 16,
  parameter int unsigned SQ_DEPTH = 16,
  parameter int unsigned LQ_W  = $clog2(LQ_DEPTH + 1),
  parameter int unsigned SQ_W  = $clog2(SQ_DEPTH + 1),
  parameter int unsigned IDX_W = (LQ_W > SQ_W) ? LQ_W : SQ_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             disp_valid_i,
  input logic             disp_store_i,
  input logic             lq_commit_i,
  input logic             sq_commit_i,
  input logic             alloc_ok_o,
  input logic             alloc_err_o,
  input logic             alloc_peer_vld_o,
  input logic [IDX_W-1:0] free_o,
  input logic             lq_full_o,
  input logic             sq_full_o,
  input logic [LQ_W-1:0]  lq_head_o,
  input logic [LQ_W-1:0]  lq_tail_o,
  input logic [LQ_W-1:0]  lq_count_o,
  input logic [SQ_W-1:0]  sq_head_o,
  input logic [SQ_W-1:0]  sq_tail_o,
  input logic [SQ_W-1:0]  sq_wb_o,
  input logic [SQ_W-1:0]  sq_count_o
);
  // R1
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (lq_count_o == 0 && sq_count_o == 0 && lq_tail_o == 0 &&
                 lq_head_o == 0 && sq_tail_o == 0 && sq_wb_o == 0));
  // R2
  lq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lq_full_o == (32'(lq_count_o) == LQ_DEPTH));
  // R2
  sq_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sq_full_o == (32'(sq_count_o) == SQ_DEPTH));
  // R3
  drop_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_err_o && !disp_store_i && !lq_commit_i) |=> $stable(lq_tail_o) && $stable(lq_count_o));
  // R3
  err_ok_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(alloc_err_o && alloc_ok_o));
  // R4
  load_no_peer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_ok_o && !disp_store_i && sq_count_o == 0) |-> !alloc_peer_vld_o);
  // R7
  free_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(free_o) + 32'(lq_count_o) <= LQ_DEPTH) && (32'(free_o) + 32'(sq_count_o) <= SQ_DEPTH));
  // R8
  lq_empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lq_commit_i && lq_count_o == 0 && !flush_i) |=> $stable(lq_head_o));
  // R9
  lq_both_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_ok_o && !disp_store_i && lq_commit_i && lq_count_o != 0) |=> $stable(lq_count_o));
  // R10
  sq_unwritten_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_commit_i && sq_head_o == sq_wb_o && !flush_i) |=> $stable(sq_head_o));
endmodule

bind lsq_alloc lsq_alloc_chk #(.LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
  .disp_valid_i(disp_valid_i), .disp_store_i(disp_store_i),
  .lq_commit_i(lq_commit_i), .sq_commit_i(sq_commit_i),
  .alloc_ok_o(alloc_ok_o), .alloc_err_o(alloc_err_o),
  .alloc_peer_vld_o(alloc_peer_vld_o), .free_o(free_o),
  .lq_full_o(lq_full_o), .sq_full_o(sq_full_o),
  .lq_head_o(lq_head_o), .lq_tail_o(lq_tail_o), .lq_count_o(lq_count_o),
  .sq_head_o(sq_head_o), .sq_tail_o(sq_tail_o), .sq_wb_o(sq_wb_o),
  .sq_count_o(sq_count_o)
);

// File: tb/tb_lsq_alloc.sv
`timescale 1ns/1ps
module tb_lsq_alloc;
  localparam int LD = 3;
  localparam int SD = 2;
  localparam int LW = $clog2(LD + 1);
  localparam int SW = $clog2(SD + 1);
  localparam int IW = (LW > SW) ? LW : SW;

  logic clk_i = 0, rst_ni = 0;
  logic flush_i = 0, disp_valid_i = 0, disp_store_i = 0;
  logic lq_commit_i = 0, sq_wb_i = 0, sq_commit_i = 0;
  logic alloc_ok_o, alloc_err_o, alloc_peer_vld_o, lq_full_o, sq_full_o;
  logic [IW-1:0] alloc_idx_o, alloc_peer_idx_o, free_o;
  logic [LW-1:0] lq_head_o, lq_tail_o, lq_count_o;
  logic [SW-1:0] sq_head_o, sq_tail_o, sq_wb_o, sq_count_o;

  lsq_alloc #(.LQ_DEPTH(LD), .SQ_DEPTH(SD)) dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int lh, lt, lc, sh, st, sw, sc;
  bit prev_flush;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int nx(int v, int depth);
    return (v == depth) ? 0 : v + 1;
  endfunction

  task automatic check_state();
    string tp, th, tc, tw;
    tp = prev_flush ? "R1" : "R6";
    th = prev_flush ? "R1" : "R8";
    tc = prev_flush ? "R1" : "R9";
    tw = prev_flush ? "R1" : "R10";
    chk(tp, int'(lq_tail_o), lt);
    chk(tp, int'(sq_tail_o), st);
    chk(th, int'(lq_head_o), lh);
    chk(th, int'(sq_head_o), sh);
    chk(tc, int'(lq_count_o), lc);
    chk(tc, int'(sq_count_o), sc);
    chk(tw, int'(sq_wb_o), sw);
  endtask

  task automatic step(bit dv, bit s, bit lcm, bit scm, bit wb, bit fl);
    bit full, acc, lpop, spop, wadv;
    @(negedge clk_i);
    disp_valid_i = dv; disp_store_i = s; lq_commit_i = lcm;
    sq_commit_i = scm; sq_wb_i = wb; flush_i = fl;
    #1;
    check_state();
    full = s ? (sc == SD) : (lc == LD);
    acc  = dv && !fl && !full;
    chk("R2", int'(lq_full_o), int'(lc == LD));
    chk("R2", int'(sq_full_o), int'(sc == SD));
    chk("R3", int'(alloc_err_o), int'(dv && !fl && full));
    chk("R3", int'(alloc_ok_o), int'(acc));
    chk("R7", int'(free_o), ((LD - lc) < (SD - sc)) ? (LD - lc) : (SD - sc));
    if (acc && s) begin
      chk("R5", int'(alloc_idx_o), st);
      chk("R5", int'(alloc_peer_idx_o), lt);
      chk("R5", int'(alloc_peer_vld_o), 1);
    end else if (acc) begin
      chk("R4", int'(alloc_idx_o), lt);
      chk("R4", int'(alloc_peer_vld_o), int'(sc != 0));
      if (sc != 0) chk("R4", int'(alloc_peer_idx_o), st);
    end
    @(posedge clk_i);
    prev_flush = fl;
    if (fl) begin
      lh = 0; lt = 0; lc = 0; sh = 0; st = 0; sw = 0; sc = 0;
    end else begin
      lpop = lcm && lc != 0;
      spop = scm && sh != sw;
      wadv = wb && sw != st;
      if (wadv) sw = nx(sw, SD);
      if (acc && !s) begin lt = nx(lt, LD); lc++; end
      if (acc && s)  begin st = nx(st, SD); sc++; end
      if (lpop) begin lh = nx(lh, LD); lc--; end
      if (spop) begin sh = nx(sh, SD); sc--; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    lh = 0; lt = 0; lc = 0; sh = 0; st = 0; sw = 0; sc = 0;
    prev_flush = 1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    // R1 reset state checked by first step
    // fill load queue past capacity (R2, R3), then drain and wrap (R6, R8)
    for (int i = 0; i < LD + 2; i++) step(1, 0, 0, 0, 0, 0);
    for (int i = 0; i < LD + 2; i++) step(0, 0, 1, 0, 0, 0);
    // stores: overflow, commit without writeback, writeback past tail (R10)
    for (int i = 0; i < SD + 1; i++) step(1, 1, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 0);
    for (int i = 0; i < SD + 1; i++) step(0, 0, 0, 0, 1, 0);
    for (int i = 0; i < SD + 1; i++) step(1, 0, 0, 1, 0, 0);
    // insert and commit together (R9)
    for (int i = 0; i < 6; i++) step(1, 0, 1, 0, 0, 0);
    step(1, 1, 0, 0, 0, 1);
    // sweep of all control combinations
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], lfsr[1], lfsr[2], lfsr[3], lfsr[4], (i % 97) == 50);
    end
    step(0, 0, 0, 0, 0, 0);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule